// File: doc/BRIEF.md
# Thirty-Two-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a simple processor datapath. Two 32-bit operands enter together with a 4-bit operation code, and within the same cycle the block returns a 32-bit result, a flag that marks an all-zero result, and a flag that marks signed overflow. The datapath uses it in three ways: to compute register-to-register arithmetic and logic, to form load and store addresses as base plus offset, and to compare two registers for a conditional branch by subtracting them and testing the zero flag.

Six operations are provided: bitwise AND, OR and NOR, addition, subtraction, and a signed less-than test. The less-than test has no comparator of its own. It reuses the subtractor, and takes the sign of the difference corrected by the subtraction's overflow, so the answer stays right even when the difference does not fit in 32 bits. Operation codes outside the six defined ones give an all-zero result.

Top module: `alu32_core`

## Requirements
- R1: Operation code 4'b0000 gives the bitwise AND of the operands, and code 4'b0001 gives their bitwise OR.
- R2: Operation code 4'b0010 gives opnd_a plus opnd_b, modulo 2^32. A carry out of bit 31 is dropped.
- R3: Operation code 4'b0110 gives opnd_a minus opnd_b, modulo 2^32.
- R4: Operation code 4'b0111 gives 1 in bit 0 and 0 in bits 31..1 when opnd_a is less than opnd_b, both read as two's-complement signed numbers. Otherwise the whole result is 0. The answer is correct also when opnd_a minus opnd_b overflows.
- R5: Operation code 4'b1100 gives the bitwise NOR of the operands.
- R6: zero is 1 exactly when all 32 bits of result are 0, for every operation code.
- R7: overflow is 1 for code 4'b0010 when both operands have the same sign bit and the sum's sign bit differs from it. For code 4'b0110 it is 1 when the operands' sign bits differ and the difference's sign bit differs from opnd_a's. For every other code it is 0.
- R8: Every operation code other than 0000, 0001, 0010, 0110, 0111 and 1100 gives a result of 0, and so zero 1 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand (minuend for subtraction and less-than) |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Operation result |
| zero | output | 1 | 1 when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The assertions sit in combinational processes and check the outputs whenever inputs change. They assume that op_sel and both operands carry only 0 and 1 values, and that all three inputs settle together before anyone looks at the outputs. The bench keeps within this by changing all inputs in one step on the falling edge of its own clock and reading the outputs a nanosecond later. The stimulus includes sign-boundary operands (the most negative value, the most positive value, all ones) that stress the overflow rule and the overflow-corrected less-than, and it sweeps every one of the sixteen operation codes.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  // Operations that use the subtracting form of the adder.
  function automatic logic op_needs_sub(input logic [OP_W-1:0] code);
    return (code == OP_SUB) || (code == OP_SLT);
  endfunction

  // Operations that report signed overflow at the port.
  function automatic logic op_is_arith(input logic [OP_W-1:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction

endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             ovf_raw
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] gen_v;
  logic [WIDTH-1:0] prop_v;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign b_eff[gi]  = b[gi] ^ sub;
      assign gen_v[gi]  = a[gi] & b_eff[gi];
      assign prop_v[gi] = a[gi] ^ b_eff[gi];
    end
  endgenerate

  // Carry chain: a subtraction injects its +1 as the carry into bit 0.
  always_comb begin
    logic carry;
    carry = sub;
    for (int i = 0; i < WIDTH; i++) begin
      sum[i] = prop_v[i] ^ carry;
      carry  = gen_v[i] | (prop_v[i] & carry);
    end
  end

  // Signed overflow: the operands that are really added agree in sign, and the sum does not.
  assign ovf_raw = ~(a[MSB] ^ b_eff[MSB]) & (sum[MSB] ^ a[MSB]);

  always_comb begin
    if (!sub) begin
      assert_add_modulo_R2: assert (sum == a + b)
        else $error("adder sum mismatch");
    end else begin
      assert_sub_modulo_R3: assert (sum == a - b)
        else $error("subtractor difference mismatch");
    end
  end

endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] and_v,
  output logic [WIDTH-1:0] or_v,
  output logic [WIDTH-1:0] nor_v
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign and_v[gi] = a[gi] & b[gi];
      assign or_v[gi]  = a[gi] | b[gi];
      assign nor_v[gi] = ~(a[gi] | b[gi]);
    end
  endgenerate

endmodule

// File: rtl/alu32_select.sv
module alu32_select
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] and_v,
  input  logic [WIDTH-1:0] or_v,
  input  logic [WIDTH-1:0] nor_v,
  input  logic [WIDTH-1:0] sum,
  input  logic             ovf_raw,
  output logic [WIDTH-1:0] result,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  logic less_bit;

  // Signed less-than: difference sign corrected by difference overflow.
  assign less_bit = sum[MSB] ^ ovf_raw;

  always_comb begin
    unique case (alu_op_e'(op))
      OP_AND:  result = and_v;
      OP_OR:   result = or_v;
      OP_ADD:  result = sum;
      OP_SUB:  result = sum;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, less_bit};
      OP_NOR:  result = nor_v;
      default: result = '0;
    endcase
  end

  assign overflow = op_is_arith(op) & ovf_raw;

endmodule

// File: rtl/alu32_zero.sv
module alu32_zero #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);

  assign is_zero = ~|value;

endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu32_pkg::*;
(
  input  logic [3:0]  op_sel,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  output logic [31:0] result,
  output logic        zero,
  output logic        overflow
);

  localparam int WIDTH = 32;
  localparam int MSB   = WIDTH - 1;

  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic [WIDTH-1:0] nor_v;
  logic [WIDTH-1:0] sum;
  logic             ovf_raw;
  logic             do_sub;

  assign do_sub = op_needs_sub(op_sel);

  alu32_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a       (opnd_a),
    .b       (opnd_b),
    .sub     (do_sub),
    .sum     (sum),
    .ovf_raw (ovf_raw)
  );

  alu32_logic #(.WIDTH(WIDTH)) u_logic (
    .a     (opnd_a),
    .b     (opnd_b),
    .and_v (and_v),
    .or_v  (or_v),
    .nor_v (nor_v)
  );

  alu32_select #(.WIDTH(WIDTH)) u_select (
    .op       (op_sel),
    .and_v    (and_v),
    .or_v     (or_v),
    .nor_v    (nor_v),
    .sum      (sum),
    .ovf_raw  (ovf_raw),
    .result   (result),
    .overflow (overflow)
  );

  alu32_zero #(.WIDTH(WIDTH)) u_zero (
    .value   (result),
    .is_zero (zero)
  );

  always_comb begin
    if (op_sel == OP_SLT) begin
      assert_slt_signed_R4: assert (result == {{(WIDTH-1){1'b0}},
                                               ($signed(opnd_a) < $signed(opnd_b))})
        else $error("less-than result wrong");
    end
    if (!op_is_arith(op_sel)) begin
      assert_no_overflow_R7: assert (!overflow)
        else $error("overflow raised outside add/subtract");
    end
    if (op_sel == OP_SUB) begin
      assert_sub_zero_R6: assert (zero == (opnd_a == opnd_b))
        else $error("zero flag disagrees with operand equality");
    end
    if (op_sel == OP_ADD) begin
      assert_add_overflow_R7: assert (overflow == ((opnd_a[MSB] == opnd_b[MSB]) &&
                                                  (result[MSB] != opnd_a[MSB])))
        else $error("add overflow flag wrong");
    end
    if (op_sel inside {4'b0011, 4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1010,
                       4'b1011, 4'b1101, 4'b1110, 4'b1111}) begin
      assert_unused_zero_R8: assert (result == '0 && zero)
        else $error("unused code gave nonzero result");
    end
  end

endmodule

// File: tb/alu32_core_test.sv
module alu32_core_test;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [31:0] result;
  logic        zero;
  logic        overflow;

  int  n_tests;
  int  n_fail;
  bit  finished;

  alu32_core uut (
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected values from the requirements.
  function automatic logic [31:0] exp_res(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
    case (op)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return a - b;
      4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b1100: return ~(a | b);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [3:0] op, input logic [31:0] a,
                                   input logic [31:0] b);
    logic [31:0] s;
    logic [31:0] d;
    s = a + b;
    d = a - b;
    if (op == 4'b0010) return (a[31] == b[31]) && (s[31] != a[31]);
    if (op == 4'b0110) return (a[31] != b[31]) && (d[31] != a[31]);
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
    n_tests++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (op=%b a=%h b=%h)",
               req, got, want, op_sel, opnd_a, opnd_b);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_sel = op;
    opnd_a = a;
    opnd_b = b;
    #1;
  endtask

  // Apply one vector and check all three outputs against the model.
  task automatic run_vec(input string req, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b);
    logic [31:0] r;
    apply(op, a, b);
    r = exp_res(op, a, b);
    check(req, result, r);
    check({req, " zero R6"}, {31'd0, zero}, {31'd0, r == 32'd0});
    check({req, " overflow R7"}, {31'd0, overflow}, {31'd0, exp_ovf(op, a, b)});
  endtask

  task automatic t_idle;
    apply(4'b0000, 32'd0, 32'd0);
    check("idle result R1", result, 32'd0);
    check("idle zero R6", {31'd0, zero}, 32'd1);
    check("idle overflow R7", {31'd0, overflow}, 32'd0);
  endtask

  task automatic t_logic;
    run_vec("and R1", 4'b0000, 32'hF0F0_A5A5, 32'hFF00_0F0F);
    check("and const R1", result, 32'hF000_0505);
    run_vec("or R1", 4'b0001, 32'hF0F0_A5A5, 32'h0F00_0F0F);
    check("or const R1", result, 32'hFFF0_AFAF);
    run_vec("nor R5", 4'b1100, 32'h0000_0000, 32'h0000_0000);
    check("nor zeros R5", result, 32'hFFFF_FFFF);
    run_vec("nor R5", 4'b1100, 32'h1234_0000, 32'h0000_5678);
    check("nor mix R5", result, 32'hEDCB_A987);
  endtask

  task automatic t_add;
    run_vec("add R2", 4'b0010, 32'd100, 32'd23);
    check("add const R2", result, 32'd123);
    run_vec("add wrap R2", 4'b0010, 32'hFFFF_FFFF, 32'd1);
    check("add wrap zero R6", {31'd0, zero}, 32'd1);
    check("add wrap no ovf R7", {31'd0, overflow}, 32'd0);
    run_vec("add pos ovf R2", 4'b0010, 32'h7FFF_FFFF, 32'd1);
    check("add pos ovf R7", {31'd0, overflow}, 32'd1);
    run_vec("add neg ovf R2", 4'b0010, 32'h8000_0000, 32'h8000_0000);
    check("add neg ovf R7", {31'd0, overflow}, 32'd1);
    check("add neg ovf zero R6", {31'd0, zero}, 32'd1);
  endtask

  task automatic t_sub;
    run_vec("sub R3", 4'b0110, 32'd5, 32'd3);
    check("sub const R3", result, 32'd2);
    run_vec("sub equal R3", 4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    check("sub equal zero R6", {31'd0, zero}, 32'd1);
    run_vec("sub neg ovf R3", 4'b0110, 32'h8000_0000, 32'd1);
    check("sub neg ovf R7", {31'd0, overflow}, 32'd1);
    run_vec("sub min R3", 4'b0110, 32'd0, 32'h8000_0000);
    check("sub min value R3", result, 32'h8000_0000);
    check("sub min ovf R7", {31'd0, overflow}, 32'd1);
  endtask

  task automatic t_slt;
    run_vec("slt neg<pos R4", 4'b0111, 32'hFFFF_FFFF, 32'd1);
    check("slt neg<pos R4", result, 32'd1);
    run_vec("slt pos<neg R4", 4'b0111, 32'd1, 32'hFFFF_FFFF);
    check("slt pos<neg R4", result, 32'd0);
    run_vec("slt ovf true R4", 4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
    check("slt ovf true R4", result, 32'd1);
    check("slt ovf flag R7", {31'd0, overflow}, 32'd0);
    run_vec("slt ovf false R4", 4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
    check("slt ovf false R4", result, 32'd0);
    run_vec("slt equal R4", 4'b0111, 32'd42, 32'd42);
    check("slt equal R4", result, 32'd0);
  endtask

  task automatic t_unused;
    for (int c = 0; c < 16; c++) begin
      logic [3:0] code;
      code = c[3:0];
      if (!(code inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100})) begin
        apply(code, 32'hFFFF_FFFF, 32'h8000_0001);
        check("unused result R8", result, 32'd0);
        check("unused zero R8", {31'd0, zero}, 32'd1);
        check("unused overflow R8", {31'd0, overflow}, 32'd0);
      end
    end
  endtask

  task automatic t_sweep;
    logic [31:0] lfsr;
    logic [31:0] a;
    logic [31:0] b;
    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = (k % 5 == 0) ? a : lfsr;
      run_vec("sweep R1 R2 R3 R4 R5", lfsr[3:0], a, b);
    end
  endtask

  initial begin
    int cycles;
    cycles = 0;
    while (!finished && cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests  = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    op_sel   = 4'b0000;
    opnd_a   = 32'd0;
    opnd_b   = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle;
    t_logic;
    t_add;
    t_sub;
    t_slt;
    t_unused;
    t_sweep;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule